// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-visible side of a byte-oriented serial port. It has a 32-bit register window with line control, line status, interrupt enable, interrupt status, FIFO control and baud divisor registers. Two word locations lead to a transmit FIFO and a receive FIFO. Characters leave through an outgoing valid/ready byte stream and arrive through an incoming valid/ready byte stream. These two streams take the place of the physical 8N1 line, so no bit timing is modelled.

Writes complete in one cycle and use per-byte-lane strobes. Reads are registered: the data appears on the cycle after the request, and lanes that the read strobes do not select return zero. FIFO bytes always travel in the most-significant byte lane. A single level-sensitive interrupt line reports any status bit whose enable bit is set. A separate error output shows that software has asked for a DMA mode, which the block does not provide.

Top module: `sio_regbank`

## Requirements
- R1: Word addresses 0, 1, 2, 3, 4, 5, 8 and 12 are mapped to line control, line status, interrupt control, interrupt status, FIFO control, baud divisor, transmit FIFO and receive FIFO. Any other word address reads as zero, and writes to it change nothing.
- R2: Each register stores only the bits in its keep mask: line control 0xE17F0000, interrupt control 0x000F0000, interrupt status 0x00070000, FIFO control 0x001F0000, baud divisor 0x03FF0000. Line status always reads zero and ignores writes.
- R3: While reset is held, both FIFOs are empty and every register is zero, except line control (0x40000000) and baud divisor (0x03FF0000).
- R4: A write changes only the byte lanes whose strobe is set. Strobe bit k covers data bits 8k+7:8k.
- R5: A write to interrupt status ANDs the data into the stored value, lane by lane. A written 0 clears a bit and a written 1 keeps it, so software can never set a status bit.
- R6: The interrupt output is high exactly when (interrupt status AND interrupt control) is nonzero. Bit 16 enables receive, bit 17 enables transmit, bit 18 enables error. The output falls in the cycle after the write that clears the matching status or enable bit.
- R7: Status bit 16 becomes 1 at the clock edge that leaves the receive FIFO non-empty. Status bit 17 becomes 1 at the edge that leaves the transmit FIFO empty. Each stays set until software clears it, and a clear does not hold while its condition is still true.
- R8: After a FIFO control write, the receive FIFO is emptied if bits 16 and 17 are both 1, and the transmit FIFO is emptied if bits 16 and 18 are both 1. A flush bit with bit 16 at 0 does nothing.
- R9: A write to the transmit word pushes data bits 31:24, but only when strobe bit 3 is set. A push into a full 16-byte FIFO is dropped. Bytes leave on the transmit stream in the order they were pushed.
- R10: A read of the receive word with strobe bit 3 set pops one byte and returns it in bits 31:24, with the other bits zero. When the FIFO is empty the read returns zero and pops nothing. The transmit word reads zero.
- R11: The receive stream's ready output is low while the 16-byte receive FIFO is full, and a byte is accepted only when both valid and ready are high.
- R12: The DMA error output equals interrupt control bit 19.
- R13: Read data appears the cycle after the request, with unselected lanes zero. Read data is zero in any cycle that follows no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| waddr | input | 6 | Word address (byte offset divided by 4) |
| wr_en | input | 1 | Write request |
| wr_strb | input | 4 | Write byte-lane strobes |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_strb | input | 4 | Read byte-lane select |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| dma_err | output | 1 | Unsupported DMA mode requested |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte available |
| tx_ready | input | 1 | Sink accepts outgoing byte |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte offered |
| rx_ready | output | 1 | Receive FIFO has room |

## Verification
The bench goes after several corner cases, each compared against a behavioural model on every cycle:
- Overfilling the transmit FIFO: a design that wraps its pointers would lose the oldest bytes or send them twice.
- A receive FIFO held full under continuous valid: a design that ignored ready would overwrite unread data.
- Clearing the transmit-empty status while the FIFO is still empty: the bit must come back at once. A design that treated it as edge-only would leave the interrupt silent.
- Flush bits written without the enable bit: a design that ignores the enable would lose data.
- Reads of an empty receive FIFO and reads without the top-lane select: either one must leave the FIFO contents untouched.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  localparam logic [5:0] W_LCR = 6'd0;
  localparam logic [5:0] W_LSR = 6'd1;
  localparam logic [5:0] W_ICR = 6'd2;
  localparam logic [5:0] W_ISR = 6'd3;
  localparam logic [5:0] W_FCR = 6'd4;
  localparam logic [5:0] W_BDR = 6'd5;
  localparam logic [5:0] W_TXF = 6'd8;
  localparam logic [5:0] W_RXF = 6'd12;

  localparam logic [31:0] KEEP_LCR = 32'hE17F0000;
  localparam logic [31:0] KEEP_ICR = 32'h000F0000;
  localparam logic [31:0] KEEP_ISR = 32'h00070000;
  localparam logic [31:0] KEEP_FCR = 32'h001F0000;
  localparam logic [31:0] KEEP_BDR = 32'h03FF0000;
  localparam logic [31:0] INIT_LCR = 32'h40000000;
  localparam logic [31:0] INIT_BDR = 32'h03FF0000;

  // bit positions inside interrupt and FIFO control words
  localparam int B_RX   = 16;
  localparam int B_TX   = 17;
  localparam int B_DMA  = 19;
  localparam int B_FEN  = 16;
  localparam int B_FRX  = 17;
  localparam int B_FTX  = 18;

  function automatic logic [31:0] lane_bits(input logic [3:0] s);
    lane_bits = {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
  endfunction

  function automatic logic [31:0] merge_lanes(input logic [31:0] old_v, input logic [31:0] wd,
                                              input logic [3:0] s, input logic [31:0] keep);
    logic [31:0] lm;
    lm = lane_bits(s);
    merge_lanes = ((old_v & ~lm) | (wd & lm)) & keep;
  endfunction

  function automatic logic [31:0] and_lanes(input logic [31:0] old_v, input logic [31:0] wd,
                                            input logic [3:0] s, input logic [31:0] keep);
    and_lanes = old_v & (wd | ~lane_bits(s)) & keep;
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level,
  output logic [LW-1:0] level_nxt
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];
  assign level_nxt = flush ? '0 : level + LW'(do_push) - LW'(do_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      level <= level_nxt;
      if (flush) begin
        rd_ptr <= '0;
        wr_ptr <= '0;
      end else begin
        if (do_push) wr_ptr <= bump(wr_ptr);
        if (do_pop)  rd_ptr <= bump(rd_ptr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end

  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(level));
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> full);
endmodule

// File: rtl/sio_int_unit.sv
module sio_int_unit
  import sio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_icr,
  input  logic        wr_isr,
  input  logic [31:0] wr_data,
  input  logic [3:0]  wr_strb,
  input  logic        rx_nonempty_nxt,
  input  logic        tx_empty_nxt,
  output logic [31:0] icr_q,
  output logic [31:0] isr_q,
  output logic        irq,
  output logic        dma_err
);
  logic [31:0] isr_base, isr_nxt, icr_nxt, raise;

  always_comb begin
    icr_nxt  = wr_icr ? merge_lanes(icr_q, wr_data, wr_strb, KEEP_ICR) : icr_q;
    isr_base = wr_isr ? and_lanes(isr_q, wr_data, wr_strb, KEEP_ISR) : isr_q;
    raise    = '0;
    raise[B_RX] = rx_nonempty_nxt;
    raise[B_TX] = tx_empty_nxt;
    isr_nxt  = isr_base | raise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icr_q <= '0;
      isr_q <= '0;
    end else begin
      icr_q <= icr_nxt;
      isr_q <= isr_nxt;
    end
  end

  assign irq     = |(isr_q & icr_q);
  assign dma_err = icr_q[B_DMA];

  p_sw_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_isr && !rx_nonempty_nxt && !tx_empty_nxt) |=> ((isr_q & ~$past(isr_q)) == '0));
  p_irq_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_icr && wr_strb == 4'hF && wr_data == '0) |=> !irq);
  p_dma_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_icr && wr_strb[2] && wr_data[B_DMA]) |=> dma_err);
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
  import sio_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  waddr,
  input  logic        wr_en,
  input  logic [3:0]  wr_strb,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [3:0]  rd_strb,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        dma_err,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        rx_ready
);
  logic [31:0] lcr_q, fcr_q, bdr_q, icr_q, isr_q;
  logic [31:0] fcr_nxt, rd_word;
  logic        wr_lcr, wr_icr, wr_isr, wr_fcr, wr_bdr;
  logic        tx_push, tx_pop, tx_flush, tx_empty, tx_full;
  logic        rx_push, rx_pop, rx_flush, rx_empty, rx_full;
  logic [7:0]  rx_head;
  logic [LW-1:0] tx_lvl, tx_lvl_nxt, rx_lvl, rx_lvl_nxt;

  // decoded write and FIFO events, visible to the assertions
  assign wr_lcr  = wr_en && (waddr == W_LCR);
  assign wr_icr  = wr_en && (waddr == W_ICR);
  assign wr_isr  = wr_en && (waddr == W_ISR);
  assign wr_fcr  = wr_en && (waddr == W_FCR);
  assign wr_bdr  = wr_en && (waddr == W_BDR);
  assign tx_push = wr_en && (waddr == W_TXF) && wr_strb[3];
  assign rx_pop  = rd_en && (waddr == W_RXF) && rd_strb[3];
  assign tx_pop  = tx_valid && tx_ready;
  assign rx_push = rx_valid && rx_ready;
  assign fcr_nxt = wr_fcr ? merge_lanes(fcr_q, wr_data, wr_strb, KEEP_FCR) : fcr_q;
  assign rx_flush = wr_fcr && fcr_nxt[B_FEN] && fcr_nxt[B_FRX];
  assign tx_flush = wr_fcr && fcr_nxt[B_FEN] && fcr_nxt[B_FTX];
  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push), .din(wr_data[31:24]),
    .pop(tx_pop), .dout(tx_data), .empty(tx_empty), .full(tx_full),
    .level(tx_lvl), .level_nxt(tx_lvl_nxt));

  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .din(rx_data),
    .pop(rx_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full),
    .level(rx_lvl), .level_nxt(rx_lvl_nxt));

  sio_int_unit u_int (
    .clk(clk), .rst_n(rst_n), .wr_icr(wr_icr), .wr_isr(wr_isr),
    .wr_data(wr_data), .wr_strb(wr_strb),
    .rx_nonempty_nxt(rx_lvl_nxt != '0), .tx_empty_nxt(tx_lvl_nxt == '0),
    .icr_q(icr_q), .isr_q(isr_q), .irq(irq), .dma_err(dma_err));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q <= INIT_LCR;
      fcr_q <= '0;
      bdr_q <= INIT_BDR;
    end else begin
      if (wr_lcr) lcr_q <= merge_lanes(lcr_q, wr_data, wr_strb, KEEP_LCR);
      if (wr_bdr) bdr_q <= merge_lanes(bdr_q, wr_data, wr_strb, KEEP_BDR);
      fcr_q <= fcr_nxt;
    end
  end

  always_comb begin
    case (waddr)
      W_LCR:   rd_word = lcr_q;
      W_LSR:   rd_word = '0;
      W_ICR:   rd_word = icr_q;
      W_ISR:   rd_word = isr_q;
      W_FCR:   rd_word = fcr_q;
      W_BDR:   rd_word = bdr_q;
      W_RXF:   rd_word = rx_empty ? '0 : {rx_head, 24'h0};
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_en ? (rd_word & lane_bits(rd_strb)) : '0;
  end

  p_rd_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && waddr == W_LCR && rd_strb == 4'hF) |=> (rd_data == $past(lcr_q)));
  p_tx_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && waddr == W_TXF && !wr_strb[3]) |=> (tx_lvl <= $past(tx_lvl)));
  p_rx_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_pop && !rx_flush) |=> !rx_ready);
  p_unmapped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && waddr == 6'd6) |=> (rd_data == '0));
endmodule

// File: tb/sio_regbank_test.sv
module sio_regbank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  waddr = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_strb = 0;
  logic [31:0] wr_data = 0;
  logic        rd_en = 0;
  logic [3:0]  rd_strb = 0;
  logic [31:0] rd_data;
  logic        irq, dma_err, tx_valid, rx_ready;
  logic [7:0]  tx_data;
  logic        tx_ready = 0;
  logic [7:0]  rx_data = 0;
  logic        rx_valid = 0;

  sio_regbank uut (.*);

  always #5 clk = ~clk;

  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;
  string phase = "R3";

  // behavioural reference model
  logic [31:0] m_lcr = 32'h40000000, m_icr = 0, m_isr = 0, m_fcr = 0, m_bdr = 32'h03FF0000, m_rd = 0;
  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];

  function automatic logic [31:0] lanes(input logic [3:0] s);
    logic [31:0] r = 0;
    for (int k = 0; k < 4; k++) if (s[k]) r[8*k +: 8] = 8'hFF;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lcr = 32'h40000000; m_icr = 0; m_isr = 0; m_fcr = 0; m_bdr = 32'h03FF0000; m_rd = 0;
      txq.delete(); rxq.delete();
    end else begin
      automatic bit txfull = (txq.size() == 16);
      automatic bit rxfull = (rxq.size() == 16);
      automatic logic [31:0] v = 0;
      automatic logic [31:0] lm = lanes(wr_strb);
      if (rd_en) begin
        case (waddr)
          0: v = m_lcr;  2: v = m_icr;  3: v = m_isr;  4: v = m_fcr;  5: v = m_bdr;
          12: v = (rxq.size() > 0) ? {rxq[0], 24'h0} : 0;
          default: v = 0;
        endcase
        m_rd = v & lanes(rd_strb);
        if (waddr == 12 && rd_strb[3] && rxq.size() > 0) void'(rxq.pop_front());
      end else m_rd = 0;
      if (txq.size() > 0 && tx_ready) void'(txq.pop_front());
      if (wr_en && waddr == 8 && wr_strb[3] && !txfull) txq.push_back(wr_data[31:24]);
      if (rx_valid && !rxfull) rxq.push_back(rx_data);
      if (wr_en) begin
        case (waddr)
          0: m_lcr = ((m_lcr & ~lm) | (wr_data & lm)) & 32'hE17F0000;
          2: m_icr = ((m_icr & ~lm) | (wr_data & lm)) & 32'h000F0000;
          3: m_isr = m_isr & (wr_data | ~lm) & 32'h00070000;
          4: begin
               m_fcr = ((m_fcr & ~lm) | (wr_data & lm)) & 32'h001F0000;
               if (m_fcr[16] && m_fcr[17]) rxq.delete();
               if (m_fcr[16] && m_fcr[18]) txq.delete();
             end
          5: m_bdr = ((m_bdr & ~lm) | (wr_data & lm)) & 32'h03FF0000;
          default: ;
        endcase
      end
      if (rxq.size() > 0)  m_isr[16] = 1'b1;
      if (txq.size() == 0) m_isr[17] = 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      chk({"rd_data ", phase}, rd_data, m_rd);
      chk("irq R6", {31'b0, irq}, {31'b0, |(m_isr & m_icr)});
      chk("dma_err R12", {31'b0, dma_err}, {31'b0, m_icr[19]});
      chk("tx_valid R9", {31'b0, tx_valid}, {31'b0, txq.size() > 0});
      if (txq.size() > 0) chk("tx_data R9", {24'b0, tx_data}, {24'b0, txq[0]});
      chk("rx_ready R11", {31'b0, rx_ready}, {31'b0, rxq.size() < 16});
      if (cyc > 150000) begin
        mismatched++;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
        finish_run();
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk); waddr = a; wr_data = d; wr_strb = s; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [3:0] s);
    @(negedge clk); waddr = a; rd_strb = s; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R3: values held under reset, then read back
    idle(3); rst_n = 1; idle(1);
    rd(0, 4'hF); rd(5, 4'hF); rd(2, 4'hF); rd(4, 4'hF); rd(3, 4'hF);
    // R2: keep masks and read-only line status
    phase = "R2";
    for (int a = 0; a < 6; a++) begin wr(6'(a), 32'hFFFFFFFF, 4'hF); rd(6'(a), 4'hF); end
    wr(2, 0, 4'hF); wr(4, 0, 4'hF);
    // R1: unmapped addresses
    phase = "R1";
    wr(6, 32'hFFFFFFFF, 4'hF); rd(6, 4'hF); rd(7, 4'hF); rd(63, 4'hF); rd(9, 4'hF);
    // R4: single-lane writes
    phase = "R4";
    wr(0, 32'h00000000, 4'b0100); rd(0, 4'hF);
    wr(5, 32'h00000000, 4'b1000); rd(5, 4'hF);
    wr(0, 32'hA5A5A5A5, 4'b1010); rd(0, 4'hF);
    // R13: partial read select and idle read data
    phase = "R13";
    rd(0, 4'b0011); rd(0, 4'b1000); idle(2);
    // R12: DMA request flag
    phase = "R12";
    wr(2, 32'h00080000, 4'b0100); rd(2, 4'hF); wr(2, 0, 4'b0100);
    // R9: fill transmit FIFO past full, lane-3 gating
    phase = "R9";
    tx_ready = 0;
    for (int i = 0; i < 18; i++) wr(8, {8'(i + 8'h30), 24'hFFFFFF}, 4'hF);
    wr(8, 32'h00EEEEEE, 4'b0111);
    rd(8, 4'hF);
    // R7 / R6: clear status while TX busy, enable TX interrupt, drain
    phase = "R7";
    wr(3, 0, 4'hF); rd(3, 4'hF);
    wr(2, 32'h00020000, 4'hF);
    @(negedge clk); tx_ready = 1;
    idle(20); tx_ready = 0;
    rd(3, 4'hF);
    wr(3, 0, 4'hF); rd(3, 4'hF);
    phase = "R6";
    wr(2, 0, 4'hF); idle(1);
    // R11: flood receive side
    phase = "R11";
    @(negedge clk); rx_valid = 1;
    for (int i = 0; i < 20; i++) begin rx_data = 8'(8'h80 + i); @(negedge clk); end
    rx_valid = 0;
    // R10: pops, non-selecting reads, transmit word
    phase = "R10";
    rd(12, 4'b0111); rd(12, 4'b1000); rd(12, 4'hF); rd(8, 4'hF);
    wr(2, 32'h00010000, 4'hF); idle(1);
    // R5: writing ones keeps, cannot set
    phase = "R5";
    wr(3, 32'hFFFFFFFF, 4'hF); rd(3, 4'hF);
    wr(3, 32'h00000000, 4'b1011); rd(3, 4'hF);
    // R8: flush without and with enable
    phase = "R8";
    wr(4, 32'h00020000, 4'hF); rd(12, 4'b1000);
    wr(4, 32'h00030000, 4'hF); rd(12, 4'b1000); rd(4, 4'hF);
    wr(8, 32'h11000000, 4'b1000); wr(8, 32'h22000000, 4'b1000);
    wr(4, 32'h00040000, 4'hF); idle(1);
    wr(4, 32'h00050000, 4'hF); idle(1);
    wr(3, 0, 4'hF); rd(3, 4'hF);
    // R10: empty receive read
    phase = "R10";
    for (int i = 0; i < 3; i++) rd(12, 4'hF);
    idle(3);
    finish_run();
  end
endmodule